// File: doc/BRIEF.md
# Split Integer-Fraction Threshold Checker

This block screens the results of converter self-test steps against programmable limits and raises sticky error flags. One self-test algorithm delivers each result as an integer field with a fractional field beside it. The integer field is judged first against a high and a low limit. The fraction is consulted only when the integer lands exactly on one of those limits, and then it is compared with a matching fractional limit.

A second algorithm measures the reference against itself. The ideal code is full scale, 0xFFF at 12 bits, so that step uses only a lower limit.

A third algorithm starts with a step that measures an offset. The block stores that value and can check it against its own window. On every later step of that algorithm, the block subtracts the stored offset from the result, with the difference held at zero rather than wrapping. It then checks the corrected value against a calibration window.

All limits and enables are plain configuration inputs. A result-valid strobe qualifies each comparison. Each of the three algorithms has its own error flag, and software clears a flag by pulsing the matching bit of a write-one-to-clear input.

Top module: `ifthr_checker`

## Requirements
- R1: For a split step (step_i = 0), an integer field above int_hi_i sets err_o[0] whatever the fraction holds.
- R2: For a split step, an integer field below int_lo_i sets err_o[0] whatever the fraction holds.
- R3: For a split step whose integer field equals int_hi_i, err_o[0] is set only when the fraction is greater than frac_hi_i.
- R4: For a split step whose integer field equals int_lo_i, err_o[0] is set only when the fraction is less than frac_lo_i.
- R5: For a split step whose integer field lies strictly between the two integer limits, no error is raised for any fraction.
- R6: For a reference step (step_i = 1), err_o[1] is set only when conv_i is below ref_lo_i; there is no upper limit, so 0xFFF never fails.
- R7: An offset step 0 (step_i = 2) stores conv_i as the offset, and offset_o shows the stored value from the next clock on (0 after reset).
- R8: An offset step 0 sets err_o[2] when conv_i lies outside [ofs_lo_i, ofs_hi_i], and only while ofs_chk_en_i is 1.
- R9: A later offset step (step_i = 3) subtracts the stored offset from conv_i, saturating at zero. It sets err_o[2] when the corrected value lies outside [cal_lo_i, cal_hi_i].
- R10: Each err_o bit is sticky until the matching clr_i bit is pulsed. A clear in the same cycle as a new error on that bit leaves the bit set.
- R11: Checks happen only on cycles with valid_i high. The flags and the offset change on the clock edge that samples the strobe, and are otherwise unchanged apart from clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Result-valid strobe |
| step_i | input | 2 | Step kind: 0 split, 1 reference, 2 offset step 0, 3 later offset step |
| int_i | input | INT_W | Integer field of a split result |
| frac_i | input | FRAC_W | Fractional field of a split result |
| conv_i | input | CONV_W | Result for reference and offset steps |
| int_hi_i | input | INT_W | Integer high limit |
| int_lo_i | input | INT_W | Integer low limit |
| frac_hi_i | input | FRAC_W | Fraction high limit |
| frac_lo_i | input | FRAC_W | Fraction low limit |
| ref_lo_i | input | CONV_W | Reference-step low limit |
| ofs_chk_en_i | input | 1 | Enables the offset-step-0 window check |
| ofs_lo_i | input | CONV_W | Offset window low limit |
| ofs_hi_i | input | CONV_W | Offset window high limit |
| cal_lo_i | input | CONV_W | Corrected-result low limit |
| cal_hi_i | input | CONV_W | Corrected-result high limit |
| clr_i | input | 3 | Write-one-to-clear pulses: bit 0 split, bit 1 reference, bit 2 offset |
| err_o | output | 3 | Sticky error flags, same bit order as clr_i |
| offset_o | output | CONV_W | Stored offset |

## Verification
The assertions assume that the limits do not change in the cycle that a valid result is sampled. They also assume that the low limit of each window is not above its high limit, so that the checks on a stored offset and on a corrected value have a meaning.

The stimulus keeps the configuration constant within each phase and changes it only on cycles without a strobe. It uses ordered windows throughout, and it draws random results around the limits so that the equality cases and the saturating subtraction are reached.

// File: rtl/ifthr_pkg.sv
package ifthr_pkg;
  typedef enum logic [1:0] {
    STEP_SPLIT = 2'd0,
    STEP_REF   = 2'd1,
    STEP_OFS0  = 2'd2,
    STEP_OFSN  = 2'd3
  } step_e;

  localparam int unsigned ERR_SPLIT = 0;
  localparam int unsigned ERR_REF   = 1;
  localparam int unsigned ERR_OFS   = 2;
  localparam int unsigned N_ERR     = 3;
endpackage

// File: rtl/ifthr_split_cmp.sv
module ifthr_split_cmp #(
  parameter int unsigned INT_W  = 12,
  parameter int unsigned FRAC_W = 8
) (
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [INT_W-1:0]  int_hi_i,
  input  logic [INT_W-1:0]  int_lo_i,
  input  logic [FRAC_W-1:0] frac_hi_i,
  input  logic [FRAC_W-1:0] frac_lo_i,
  output logic              viol_o
);
  logic int_above, int_below, on_hi, on_lo;

  always_comb begin
    int_above = int_i > int_hi_i;
    int_below = int_i < int_lo_i;
    on_hi     = (int_i == int_hi_i) && (frac_i > frac_hi_i);
    on_lo     = (int_i == int_lo_i) && (frac_i < frac_lo_i);
    viol_o    = int_above | int_below | on_hi | on_lo;
  end
endmodule

// File: rtl/ifthr_window.sv
module ifthr_window #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         out_o
);
  assign out_o = (val_i < lo_i) | (val_i > hi_i);
endmodule

// File: rtl/ifthr_offset_unit.sv
module ifthr_offset_unit #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] conv_i,
  output logic [W-1:0] offset_o,
  output logic [W-1:0] corr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    offset_o <= '0;
    else if (cap_i) offset_o <= conv_i;
  end

  // saturate at zero, never wrap
  always_comb begin
    if (conv_i >= offset_o) corr_o = conv_i - offset_o;
    else                    corr_o = '0;
  end

  p_offset_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> offset_o == $past(conv_i));

  p_offset_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(offset_o));

  p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o <= conv_i);
endmodule

// File: rtl/ifthr_sticky_flag.sv
module ifthr_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= (flag_o & ~clr_i) | set_i;
  end

  p_sticky_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o);

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !flag_o);
endmodule

// File: rtl/ifthr_checker.sv
module ifthr_checker #(
  parameter int unsigned INT_W  = 12,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned CONV_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        step_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [CONV_W-1:0] conv_i,
  input  logic [INT_W-1:0]  int_hi_i,
  input  logic [INT_W-1:0]  int_lo_i,
  input  logic [FRAC_W-1:0] frac_hi_i,
  input  logic [FRAC_W-1:0] frac_lo_i,
  input  logic [CONV_W-1:0] ref_lo_i,
  input  logic              ofs_chk_en_i,
  input  logic [CONV_W-1:0] ofs_lo_i,
  input  logic [CONV_W-1:0] ofs_hi_i,
  input  logic [CONV_W-1:0] cal_lo_i,
  input  logic [CONV_W-1:0] cal_hi_i,
  input  logic [2:0]        clr_i,
  output logic [2:0]        err_o,
  output logic [CONV_W-1:0] offset_o
);
  import ifthr_pkg::*;

  step_e                step;
  logic                 split_viol, ref_viol, ofs0_viol, cal_viol;
  logic [CONV_W-1:0]    corr;
  logic [N_ERR-1:0]     err_set;
  logic                 cap;

  assign step = step_e'(step_i);
  assign cap  = valid_i && (step == STEP_OFS0);

  ifthr_split_cmp #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_split (
    .int_i    (int_i),
    .frac_i   (frac_i),
    .int_hi_i (int_hi_i),
    .int_lo_i (int_lo_i),
    .frac_hi_i(frac_hi_i),
    .frac_lo_i(frac_lo_i),
    .viol_o   (split_viol)
  );

  // full-scale ideal: lower limit only
  assign ref_viol = conv_i < ref_lo_i;

  ifthr_offset_unit #(.W(CONV_W)) i_ofs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .conv_i  (conv_i),
    .offset_o(offset_o),
    .corr_o  (corr)
  );

  ifthr_window #(.W(CONV_W)) i_win_ofs0 (
    .val_i(conv_i),
    .lo_i (ofs_lo_i),
    .hi_i (ofs_hi_i),
    .out_o(ofs0_viol)
  );

  ifthr_window #(.W(CONV_W)) i_win_cal (
    .val_i(corr),
    .lo_i (cal_lo_i),
    .hi_i (cal_hi_i),
    .out_o(cal_viol)
  );

  always_comb begin
    err_set            = '0;
    err_set[ERR_SPLIT] = valid_i && (step == STEP_SPLIT) && split_viol;
    err_set[ERR_REF]   = valid_i && (step == STEP_REF) && ref_viol;
    err_set[ERR_OFS]   = valid_i && (((step == STEP_OFS0) && ofs_chk_en_i && ofs0_viol) ||
                                     ((step == STEP_OFSN) && cal_viol));
  end

  for (genvar g = 0; g < N_ERR; g++) begin : g_flag
    ifthr_sticky_flag i_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (err_set[g]),
      .clr_i (clr_i[g]),
      .flag_o(err_o[g])
    );
  end

  p_int_above_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && step_i == 2'd0 && int_i > int_hi_i |=> err_o[0]);

  p_int_below_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && step_i == 2'd0 && int_i < int_lo_i |=> err_o[0]);

  p_inside_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && step_i == 2'd0 && int_i > int_lo_i && int_i < int_hi_i &&
    !err_o[0] && !clr_i[0] |=> !err_o[0]);

  p_ref_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && step_i == 2'd1 && conv_i < ref_lo_i |=> err_o[1]);

  p_ofs0_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && step_i == 2'd2 && !ofs_chk_en_i && !err_o[2] && !clr_i[2] |=> !err_o[2]);

  p_no_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && clr_i == 3'b000 |=> $stable(err_o));
endmodule

// File: tb/test_ifthr_checker.sv
module test_ifthr_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  step = 2'd0;
  logic [11:0] int_v = '0;
  logic [7:0]  frac_v = '0;
  logic [11:0] conv = '0;
  logic [11:0] int_hi = 12'd100, int_lo = 12'd50;
  logic [7:0]  frac_hi = 8'd128, frac_lo = 8'd64;
  logic [11:0] ref_lo = 12'hF00;
  logic        ofs_en = 1'b0;
  logic [11:0] ofs_lo = 12'h010, ofs_hi = 12'h200;
  logic [11:0] cal_lo = 12'h010, cal_hi = 12'h200;
  logic [2:0]  clr = '0;
  logic [2:0]  err;
  logic [11:0] offset;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R11";
  bit    done = 0;

  logic [2:0]  m_err = '0;
  logic [11:0] m_ofs = '0;

  always #5 clk = ~clk;

  ifthr_checker i_ifthr_checker (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .step_i(step),
    .int_i(int_v), .frac_i(frac_v), .conv_i(conv),
    .int_hi_i(int_hi), .int_lo_i(int_lo), .frac_hi_i(frac_hi), .frac_lo_i(frac_lo),
    .ref_lo_i(ref_lo), .ofs_chk_en_i(ofs_en), .ofs_lo_i(ofs_lo), .ofs_hi_i(ofs_hi),
    .cal_lo_i(cal_lo), .cal_hi_i(cal_hi), .clr_i(clr),
    .err_o(err), .offset_o(offset)
  );

  function automatic bit split_bad(int i, int f, int ih, int il, int fh, int fl);
    if (i > ih) return 1;
    if (i < il) return 1;
    if (i == ih && f > fh) return 1;
    if (i == il && f < fl) return 1;
    return 0;
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_err = '0;
      m_ofs = '0;
    end else begin
      logic [2:0] s;
      int corr;
      s = '0;
      if (valid) begin
        case (step)
          2'd0: s[0] = split_bad(int_v, frac_v, int_hi, int_lo, frac_hi, frac_lo);
          2'd1: s[1] = (int'(conv) < int'(ref_lo));
          2'd2: s[2] = ofs_en && (conv < ofs_lo || conv > ofs_hi);
          default: begin
            corr = int'(conv) - int'(m_ofs);
            if (corr < 0) corr = 0;
            s[2] = (corr < int'(cal_lo)) || (corr > int'(cal_hi));
          end
        endcase
      end
      m_err = (m_err & ~clr) | s;
      if (valid && step == 2'd2) m_ofs = conv;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks += 2;
      if (err !== m_err) begin
        errors++;
        $display("FAIL %s err_o actual %b expected %b at %0t", cur_req, err, m_err, $time);
      end
      if (offset !== m_ofs) begin
        errors++;
        $display("FAIL %s offset_o actual %h expected %h at %0t", cur_req, offset, m_ofs, $time);
      end
    end
  end

  task automatic drive(input logic v, input logic [1:0] st, input logic [11:0] iv,
                       input logic [7:0] fv, input logic [11:0] cv, input logic [2:0] cl);
    @(negedge clk);
    valid = v; step = st; int_v = iv; frac_v = fv; conv = cv; clr = cl;
  endtask

  task automatic idle(input logic [2:0] cl);
    drive(1'b0, 2'd0, 12'd0, 8'd0, 12'd0, cl);
  endtask

  task automatic split_case(input int iv, input int fv);
    drive(1'b1, 2'd0, 12'(iv), 8'(fv), 12'd0, 3'b000);
    idle(3'b000);
    idle(3'b111);
    idle(3'b000);
  endtask

  task automatic finish_sim();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in phase %s", cur_req);
    finish_sim();
  end

  initial begin
    cur_req = "R10";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3'b000);

    cur_req = "R1";
    split_case(101, 0);
    split_case(4095, 255);
    cur_req = "R2";
    split_case(49, 255);
    split_case(0, 200);
    cur_req = "R3";
    split_case(100, 128);
    split_case(100, 129);
    cur_req = "R4";
    split_case(50, 64);
    split_case(50, 63);
    cur_req = "R5";
    split_case(51, 0);
    split_case(99, 255);
    split_case(75, 7);

    cur_req = "R6";
    drive(1'b1, 2'd1, 12'd0, 8'd0, 12'hFFF, 3'b000); idle(3'b000);
    drive(1'b1, 2'd1, 12'd0, 8'd0, 12'hF00, 3'b000); idle(3'b000);
    drive(1'b1, 2'd1, 12'd0, 8'd0, 12'hEFF, 3'b000); idle(3'b000);
    idle(3'b111); idle(3'b000);

    cur_req = "R7";
    drive(1'b1, 2'd2, 12'd0, 8'd0, 12'h123, 3'b000); idle(3'b000);
    cur_req = "R8";
    ofs_en = 1'b0;
    drive(1'b1, 2'd2, 12'd0, 8'd0, 12'h005, 3'b000); idle(3'b000);
    ofs_en = 1'b1;
    drive(1'b1, 2'd2, 12'd0, 8'd0, 12'h005, 3'b000); idle(3'b000);
    idle(3'b100); idle(3'b000);
    drive(1'b1, 2'd2, 12'd0, 8'd0, 12'h100, 3'b000); idle(3'b000);

    cur_req = "R9";
    drive(1'b1, 2'd3, 12'd0, 8'd0, 12'h080, 3'b000); idle(3'b000);
    idle(3'b100);
    drive(1'b1, 2'd3, 12'd0, 8'd0, 12'h180, 3'b000); idle(3'b000);
    drive(1'b1, 2'd3, 12'd0, 8'd0, 12'h400, 3'b000); idle(3'b000);
    idle(3'b100); idle(3'b000);

    cur_req = "R10";
    drive(1'b1, 2'd0, 12'd200, 8'd0, 12'd0, 3'b000);
    drive(1'b1, 2'd0, 12'd200, 8'd0, 12'd0, 3'b001);
    idle(3'b000);
    idle(3'b001);
    idle(3'b000);

    cur_req = "R11";
    for (int n = 0; n < 3000; n++) begin
      logic v;
      v = ($urandom % 3) != 0;
      drive(v, 2'($urandom), 12'(40 + $urandom % 70), 8'($urandom),
            12'($urandom), 3'(($urandom % 5 == 0) ? $urandom : 0));
    end
    idle(3'b000);
    idle(3'b000);
    finish_sim();
  end
endmodule